// File: doc/BRIEF.md
# Snooped cache line controller

This block is the snoop-facing half of a caching master in a coherent system. It keeps a coherence tag for each line of a small direct-mapped set. Each line holds an address tag, one of five line states and a line of data. The five states are Invalid, UniqueClean, UniqueDirty, SharedClean and SharedDirty. A Unique state may be written without telling other caches and a Shared state may not. A Dirty state makes this cache responsible for the eventual write-back.

The interconnect offers a snoop on a valid/ready address channel. The block looks up the addressed line and returns a four-flag response on its own valid/ready channel. When the response promises data, the block also streams the line on a separate valid/ready data channel. The response and the data may complete in either order.

Some snoops have more than one legal outcome. For these, a policy input picks the outcome. The line's new state is written only when the response handshake completes. A local install port lets the surrounding logic, or a test, set the tag, state and data of any line.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `snp_ready` is 1, and `rsp_valid` and `dat_valid` are 0. A snoop to any line then gets an all-clear response.
- R2: A miss leaves the line untouched, returns `rsp_flags` = 0000 and sends no data. A miss is a snoop whose tag (`snp_addr` bits above the index) differs from the stored tag, or whose line is Invalid. Flag bits are [3] DataTransfer, [2] PassDirty, [1] IsShared, [0] WasUnique. State codes are I=0, UC=1, UD=2, SC=3, SD=4. Snoop kinds are ReadShared=0 and ReadUnique=1.
- R3: ReadShared hitting UniqueClean responds 1011 and moves the line to SharedClean.
- R4: ReadShared hitting SharedDirty follows `snp_policy`. Policy 0 keeps SharedDirty and responds 1010. Policy 1 moves the line to SharedClean and responds 1110. Policy 2 or 3 moves it to Invalid and responds 1100.
- R5: ReadShared hitting UniqueDirty follows the same policy choice as R4, with WasUnique also set. Policy 0 goes to SharedDirty (1011), policy 1 to SharedClean (1111), and policy 2 or 3 to Invalid (1101). ReadShared hitting SharedClean responds 1010 and keeps the line.
- R6: ReadUnique hitting SharedClean invalidates the line and responds 1000. ReadUnique hitting UniqueClean invalidates it and responds 1001.
- R7: ReadUnique hitting UniqueDirty or SharedDirty invalidates the line with PassDirty and DataTransfer set: 1101 from UniqueDirty and 1100 from SharedDirty.
- R8: When DataTransfer is set, the line goes out as four 32-bit beats, lowest beat index first. `dat_last` is set on the fourth beat only. A beat is held stable while `dat_ready` is low. No beat is sent when DataTransfer is clear.
- R9: The response is presented one cycle after the snoop is accepted and is held stable until `rsp_ready`. The line state changes only at the response handshake.
- R10: Response and data complete independently, in either order. `snp_ready` stays low until both are done, and it is high in the cycle after the later of the two completes.
- R11: An install-port write replaces a line's tag and state, and data writes replace single beats. Later snoops see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_valid | input | 1 | Snoop request valid |
| snp_ready | output | 1 | Snoop request accepted when high with valid |
| snp_addr | input | 10 | Tag (upper 8 bits) and line index (lower 2 bits) |
| snp_kind | input | 1 | 0 ReadShared, 1 ReadUnique |
| snp_policy | input | 2 | Outcome selector for dirty lines under ReadShared |
| rsp_valid | output | 1 | Snoop response valid |
| rsp_ready | input | 1 | Snoop response taken |
| rsp_flags | output | 4 | DataTransfer, PassDirty, IsShared, WasUnique |
| dat_valid | output | 1 | Snoop data beat valid |
| dat_ready | input | 1 | Snoop data beat taken |
| dat_beat | output | 32 | Snoop data beat |
| dat_last | output | 1 | Final beat of the line |
| ins_tag_we | input | 1 | Install tag and state |
| ins_idx | input | 2 | Line index for install |
| ins_tag | input | 8 | Tag to install |
| ins_state | input | 3 | State code to install |
| ins_data_we | input | 1 | Install one data beat |
| ins_beat | input | 2 | Beat index for install |
| ins_data | input | 32 | Beat value to install |

## Verification
The response handshake and a data beat can land on the same clock edge. The response handshake also commits the tag-state write, and that write must not disturb the data stream. The bench varies the ready delays per vector so that both channels finish together, and in directed tests it stalls one channel for several cycles while the other drains. It judges each case by the flags and beats it collects, by `snp_ready` staying low until both channels are done, and by a follow-up ReadUnique whose response shows the committed state.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [2:0] {
    LS_I  = 3'd0,
    LS_UC = 3'd1,
    LS_UD = 3'd2,
    LS_SC = 3'd3,
    LS_SD = 3'd4
  } line_st_e;

  typedef enum logic {
    SK_RD_SHARED = 1'b0,
    SK_RD_UNIQUE = 1'b1
  } snp_kind_e;

  typedef struct packed {
    logic dt;
    logic pd;
    logic is_sh;
    logic wu;
  } snp_flags_t;
endpackage

// File: rtl/snp_tag_store.sv
module snp_tag_store
  import snp_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 8,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 32,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BIX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_tag_we,
  input  logic [IDX_W-1:0]  ins_idx,
  input  logic [TAG_W-1:0]  ins_tag,
  input  line_st_e          ins_state,
  input  logic              ins_data_we,
  input  logic [BIX_W-1:0]  ins_beat,
  input  logic [BEAT_W-1:0] ins_data,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  line_st_e          upd_state,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  output line_st_e          lk_state,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [BIX_W-1:0]  rd_beat,
  output logic [BEAT_W-1:0] rd_data
);
  logic [TAG_W-1:0]  tag_arr [LINES];
  line_st_e          st_arr  [LINES];
  logic [BEAT_W-1:0] dat_arr [LINES][BEATS];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [TAG_W-1:0] tag_q, tag_d;
    line_st_e         st_q, st_d;

    // a snoop commit wins over an install to the same line
    always_comb begin
      tag_d = tag_q;
      st_d  = st_q;
      if (upd_en && upd_idx == IDX_W'(i)) begin
        st_d = upd_state;
      end else if (ins_tag_we && ins_idx == IDX_W'(i)) begin
        tag_d = ins_tag;
        st_d  = ins_state;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= '0;
        st_q  <= LS_I;
      end else begin
        tag_q <= tag_d;
        st_q  <= st_d;
      end
    end

    assign tag_arr[i] = tag_q;
    assign st_arr[i]  = st_q;

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
      logic [BEAT_W-1:0] q;
      logic              en;
      assign en = ins_data_we && ins_idx == IDX_W'(i) && ins_beat == BIX_W'(b);
      always_ff @(posedge clk) begin
        if (en) q <= ins_data;
      end
      assign dat_arr[i][b] = q;
    end
  end

  assign lk_tag   = tag_arr[lk_idx];
  assign lk_state = st_arr[lk_idx];
  assign rd_data  = dat_arr[rd_idx][rd_beat];
endmodule

// File: rtl/snp_decide.sv
module snp_decide
  import snp_pkg::*;
(
  input  logic       hit,
  input  line_st_e   state,
  input  snp_kind_e  kind,
  input  logic [1:0] policy,
  output snp_flags_t flags,
  output line_st_e   next_state
);
  always_comb begin
    flags      = '0;
    next_state = state;
    if (hit) begin
      unique case (state)
        LS_UC: begin
          flags.wu = 1'b1;
          flags.dt = 1'b1;
          if (kind == SK_RD_UNIQUE) begin
            next_state = LS_I;
          end else begin
            flags.is_sh = 1'b1;
            next_state  = LS_SC;
          end
        end
        LS_SC: begin
          flags.dt = 1'b1;
          if (kind == SK_RD_UNIQUE) begin
            next_state = LS_I;
          end else begin
            flags.is_sh = 1'b1;
          end
        end
        LS_UD, LS_SD: begin
          flags.wu = (state == LS_UD);
          flags.dt = 1'b1;
          if (kind == SK_RD_UNIQUE) begin
            flags.pd   = 1'b1;
            next_state = LS_I;
          end else begin
            unique case (policy)
              2'd0: begin
                flags.is_sh = 1'b1;
                next_state  = LS_SD;
              end
              2'd1: begin
                flags.is_sh = 1'b1;
                flags.pd    = 1'b1;
                next_state  = LS_SC;
              end
              default: begin
                flags.pd   = 1'b1;
                next_state = LS_I;
              end
            endcase
          end
        end
        default: next_state = state;
      endcase
    end
  end
endmodule

// File: rtl/snp_beat_tx.sv
module snp_beat_tx #(
  parameter int BEATS = 4,
  localparam int BIX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dat_ready,
  output logic             dat_valid,
  output logic             dat_last,
  output logic [BIX_W-1:0] beat_idx
);
  logic             pend_q, pend_d;
  logic [BIX_W-1:0] cnt_q, cnt_d;
  logic             xfer;

  assign xfer     = pend_q && dat_ready;
  assign dat_last = (cnt_q == BIX_W'(BEATS - 1));

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (start) begin
      pend_d = 1'b1;
      cnt_d  = '0;
    end else if (xfer) begin
      cnt_d = cnt_q + 1'b1;
      if (dat_last) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dat_valid = pend_q;
  assign beat_idx  = cnt_q;
endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
  import snp_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 8,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 32,
  localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int BIX_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_kind,
  input  logic [1:0]        snp_policy,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [3:0]        rsp_flags,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [BEAT_W-1:0] dat_beat,
  output logic              dat_last,
  input  logic              ins_tag_we,
  input  logic [IDX_W-1:0]  ins_idx,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [2:0]        ins_state,
  input  logic              ins_data_we,
  input  logic [BIX_W-1:0]  ins_beat,
  input  logic [BEAT_W-1:0] ins_data
);
  logic [IDX_W-1:0] snp_idx;
  logic [TAG_W-1:0] snp_tag;
  logic [TAG_W-1:0] lk_tag;
  line_st_e         lk_state;
  logic             lk_hit;
  snp_flags_t       dec_flags;
  line_st_e         dec_next;
  logic [BIX_W-1:0] beat_idx;
  logic             accept, rsp_done;

  logic             rsp_pend_q, rsp_pend_d;
  snp_flags_t       flags_q, flags_d;
  line_st_e         next_q, next_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             hit_q, hit_d;

  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  snp_tag_store #(
    .LINES(LINES), .TAG_W(TAG_W), .BEATS(BEATS), .BEAT_W(BEAT_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_tag_we (ins_tag_we),
    .ins_idx    (ins_idx),
    .ins_tag    (ins_tag),
    .ins_state  (line_st_e'(ins_state)),
    .ins_data_we(ins_data_we),
    .ins_beat   (ins_beat),
    .ins_data   (ins_data),
    .upd_en     (rsp_done && hit_q),
    .upd_idx    (idx_q),
    .upd_state  (next_q),
    .lk_idx     (snp_idx),
    .lk_tag     (lk_tag),
    .lk_state   (lk_state),
    .rd_idx     (idx_q),
    .rd_beat    (beat_idx),
    .rd_data    (dat_beat)
  );

  assign lk_hit = (lk_tag == snp_tag) && (lk_state != LS_I);

  snp_decide u_decide (
    .hit       (lk_hit),
    .state     (lk_state),
    .kind      (snp_kind_e'(snp_kind)),
    .policy    (snp_policy),
    .flags     (dec_flags),
    .next_state(dec_next)
  );

  snp_beat_tx #(.BEATS(BEATS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept && dec_flags.dt),
    .dat_ready(dat_ready),
    .dat_valid(dat_valid),
    .dat_last (dat_last),
    .beat_idx (beat_idx)
  );

  assign snp_ready = !rsp_pend_q && !dat_valid;
  assign accept    = snp_valid && snp_ready;
  assign rsp_done  = rsp_pend_q && rsp_ready;

  always_comb begin
    rsp_pend_d = rsp_pend_q;
    flags_d    = flags_q;
    next_d     = next_q;
    idx_d      = idx_q;
    hit_d      = hit_q;
    if (accept) begin
      rsp_pend_d = 1'b1;
      flags_d    = dec_flags;
      next_d     = dec_next;
      idx_d      = snp_idx;
      hit_d      = lk_hit;
    end else if (rsp_done) begin
      rsp_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_pend_q <= 1'b0;
      flags_q    <= '0;
      next_q     <= LS_I;
      idx_q      <= '0;
      hit_q      <= 1'b0;
    end else begin
      rsp_pend_q <= rsp_pend_d;
      flags_q    <= flags_d;
      next_q     <= next_d;
      idx_q      <= idx_d;
      hit_q      <= hit_d;
    end
  end

  assign rsp_valid = rsp_pend_q;
  assign rsp_flags = flags_q;
endmodule

// File: rtl/snp_chk.sv
module snp_chk #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 32,
  localparam int CNT_W = $clog2(BEATS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snp_valid,
  input logic              snp_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [3:0]        rsp_flags,
  input logic              dat_valid,
  input logic              dat_ready,
  input logic [BEAT_W-1:0] dat_beat,
  input logic              dat_last
);
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (dat_valid && dat_ready) begin
      seen_q <= dat_last ? '0 : seen_q + 1'b1;
    end
  end

  // R8
  last_on_final_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && dat_ready && dat_last |-> seen_q == CNT_W'(BEATS - 1));

  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && !dat_ready |=> dat_valid && $stable(dat_beat) && $stable(dat_last));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_flags));

  // R9
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_ready |=> rsp_valid);

  // R2
  no_data_without_dt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_flags[3] |-> !dat_valid);

  // R7
  dirty_carries_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_flags[2] |-> rsp_flags[3]);

  // R10
  busy_blocks_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || dat_valid) |-> !snp_ready);
endmodule

bind snoop_line_ctrl snp_chk #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_snp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .snp_valid(snp_valid),
  .snp_ready(snp_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_flags(rsp_flags),
  .dat_valid(dat_valid),
  .dat_ready(dat_ready),
  .dat_beat (dat_beat),
  .dat_last (dat_last)
);

// File: tb/snoop_line_ctrl_bench.sv
module snoop_line_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        snp_valid, snp_ready, snp_kind;
  logic [9:0]  snp_addr;
  logic [1:0]  snp_policy;
  logic        rsp_valid, rsp_ready;
  logic [3:0]  rsp_flags;
  logic        dat_valid, dat_ready, dat_last;
  logic [31:0] dat_beat;
  logic        ins_tag_we, ins_data_we;
  logic [1:0]  ins_idx, ins_beat;
  logic [7:0]  ins_tag;
  logic [2:0]  ins_state;
  logic [31:0] ins_data;

  int checks = 0;
  int errors = 0;

  logic [3:0]  got_flags;
  int          got_nb;
  logic [31:0] got_beat [4];
  logic        got_last [4];
  logic        ready_leak, hold_bad;

  always #5 clk = ~clk;

  snoop_line_ctrl u_snoop_line_ctrl (.*);

  // fields: [13:11] init state, [10] kind, [9:8] policy, [7] hit,
  //         [6:3] expected flags {DT,PD,IS,WU}, [2:0] expected next state
  localparam logic [13:0] VEC [18] = '{
    {3'd0, 1'b0, 2'd0, 1'b1, 4'b0000, 3'd0},
    {3'd1, 1'b0, 2'd0, 1'b0, 4'b0000, 3'd1},
    {3'd1, 1'b0, 2'd0, 1'b1, 4'b1011, 3'd3},
    {3'd4, 1'b0, 2'd0, 1'b1, 4'b1010, 3'd4},
    {3'd4, 1'b0, 2'd1, 1'b1, 4'b1110, 3'd3},
    {3'd4, 1'b0, 2'd2, 1'b1, 4'b1100, 3'd0},
    {3'd4, 1'b0, 2'd3, 1'b1, 4'b1100, 3'd0},
    {3'd2, 1'b0, 2'd0, 1'b1, 4'b1011, 3'd4},
    {3'd2, 1'b0, 2'd1, 1'b1, 4'b1111, 3'd3},
    {3'd2, 1'b0, 2'd2, 1'b1, 4'b1101, 3'd0},
    {3'd3, 1'b0, 2'd0, 1'b1, 4'b1010, 3'd3},
    {3'd3, 1'b1, 2'd0, 1'b1, 4'b1000, 3'd0},
    {3'd1, 1'b1, 2'd0, 1'b1, 4'b1001, 3'd0},
    {3'd2, 1'b1, 2'd0, 1'b1, 4'b1101, 3'd0},
    {3'd4, 1'b1, 2'd0, 1'b1, 4'b1100, 3'd0},
    {3'd0, 1'b1, 2'd0, 1'b1, 4'b0000, 3'd0},
    {3'd4, 1'b1, 2'd0, 1'b0, 4'b0000, 3'd4},
    {3'd2, 1'b0, 2'd2, 1'b0, 4'b0000, 3'd2}
  };

  function automatic logic [31:0] pat(input int seed, input int b);
    return 32'hA500_0000 + 32'(seed) * 32'd256 + 32'(b);
  endfunction

  // ReadUnique response that reveals each state (R6, R7)
  function automatic logic [3:0] probe_flags(input logic [2:0] st);
    case (st)
      3'd1:    return 4'b1001;
      3'd2:    return 4'b1101;
      3'd3:    return 4'b1000;
      3'd4:    return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string req_of(input logic [13:0] v);
    if (!v[7] || v[13:11] == 3'd0) return "R2";
    if (v[10] == 1'b0) begin
      if (v[13:11] == 3'd1) return "R3";
      if (v[13:11] == 3'd4) return "R4";
      return "R5";
    end
    if (v[13:11] == 3'd1 || v[13:11] == 3'd3) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic install(input logic [1:0] idx, input logic [7:0] tag,
                         input logic [2:0] st, input int seed);
    ins_tag_we = 1'b1; ins_idx = idx; ins_tag = tag; ins_state = st;
    @(negedge clk);
    ins_tag_we = 1'b0;
    for (int b = 0; b < 4; b++) begin
      ins_data_we = 1'b1; ins_beat = 2'(b); ins_data = pat(seed, b);
      @(negedge clk);
    end
    ins_data_we = 1'b0;
  endtask

  task automatic run_snoop(input logic [7:0] tag, input logic [1:0] idx,
                           input logic kind, input logic [1:0] pol,
                           input int rw, input int dw);
    logic [3:0] first;
    logic       seen, got;
    first = '0;
    snp_addr = {tag, idx}; snp_kind = kind; snp_policy = pol; snp_valid = 1'b1;
    while (!snp_ready) @(negedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    got = 1'b0; seen = 1'b0; got_nb = 0; ready_leak = 1'b0; hold_bad = 1'b0;
    got_flags = 4'hF;
    for (int k = 0; k < 80; k++) begin
      if (got && !rsp_valid && !dat_valid) break;
      rsp_ready = 1'b0; dat_ready = 1'b0;
      if (snp_ready) ready_leak = 1'b1;
      if (rsp_valid && !got) begin
        if (!seen) begin first = rsp_flags; seen = 1'b1; end
        if (rsp_flags !== first) hold_bad = 1'b1;
        if (k >= rw) begin got_flags = rsp_flags; got = 1'b1; rsp_ready = 1'b1; end
      end
      if (dat_valid && k >= dw) begin
        dat_ready = 1'b1;
        if (got_nb < 4) begin
          got_beat[got_nb] = dat_beat; got_last[got_nb] = dat_last;
        end
        got_nb++;
      end
      @(negedge clk);
    end
    rsp_ready = 1'b0; dat_ready = 1'b0;
  endtask

  task automatic check_beats(input string req, input int seed);
    check(req, "beat count", 32'(got_nb), 32'd4);
    for (int b = 0; b < 4; b++) begin
      check(req, "beat data", got_beat[b], pat(seed, b));
      check(req, "beat last", 32'(got_last[b]), 32'(b == 3));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; snp_valid = 1'b0; snp_addr = '0; snp_kind = 1'b0; snp_policy = '0;
    rsp_ready = 1'b0; dat_ready = 1'b0; ins_tag_we = 1'b0; ins_data_we = 1'b0;
    ins_idx = '0; ins_beat = '0; ins_tag = '0; ins_state = '0; ins_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "snp_ready", 32'(snp_ready), 32'd1);
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1", "dat_valid", 32'(dat_valid), 32'd0);
    run_snoop(8'h00, 2'd0, 1'b0, 2'd0, 0, 0);
    check("R1", "flags after reset", 32'(got_flags), 32'd0);
    check("R1", "no data after reset", 32'(got_nb), 32'd0);
    run_snoop(8'h00, 2'd3, 1'b1, 2'd0, 0, 0);
    check("R1", "flags after reset line3", 32'(got_flags), 32'd0);

    // vector table: R2..R8
    for (int v = 0; v < 18; v++) begin
      logic [13:0] e;
      logic [7:0]  tag;
      logic [1:0]  idx;
      string       rq;
      e = VEC[v];
      rq = req_of(e);
      idx = 2'(v);
      tag = 8'h40 + 8'(v);
      install(idx, tag, e[13:11], v);
      run_snoop(e[7] ? tag : ~tag, idx, e[10], e[9:8], v % 3, (v + 1) % 3);
      check(rq, "response flags", 32'(got_flags), 32'(e[6:3]));
      if (e[6]) check_beats("R8", v);
      else check("R8", "no beats without DT", 32'(got_nb), 32'd0);
      run_snoop(tag, idx, 1'b1, 2'd0, 0, 0);
      check(rq, "next state probe", 32'(got_flags), 32'(probe_flags(e[2:0])));
    end

    // R10 response stalled, data drains first
    install(2'd1, 8'h77, 3'd2, 50);
    run_snoop(8'h77, 2'd1, 1'b0, 2'd0, 8, 0);
    check("R10", "flags rsp late", 32'(got_flags), 32'b1011);
    check_beats("R10", 50);
    check("R10", "ready low while busy", 32'(ready_leak), 32'd0);
    check("R10", "ready after both done", 32'(snp_ready), 32'd1);

    // R10 data stalled, response first
    install(2'd2, 8'h78, 3'd4, 51);
    run_snoop(8'h78, 2'd2, 1'b1, 2'd0, 0, 8);
    check("R10", "flags data late", 32'(got_flags), 32'b1100);
    check_beats("R10", 51);
    check("R10", "ready low while data busy", 32'(ready_leak), 32'd0);
    check("R10", "ready after data done", 32'(snp_ready), 32'd1);

    // R9 long response stall holds flags, commit only at handshake
    install(2'd3, 8'h31, 3'd1, 52);
    run_snoop(8'h31, 2'd3, 1'b0, 2'd0, 10, 10);
    check("R9", "flags held during stall", 32'(hold_bad), 32'd0);
    check("R9", "stalled flags", 32'(got_flags), 32'b1011);
    run_snoop(8'h31, 2'd3, 1'b1, 2'd0, 0, 0);
    check("R9", "state after late handshake", 32'(got_flags), 32'b1000);

    // R11 install overwrite of tag, state and one beat
    install(2'd0, 8'h12, 3'd2, 9);
    install(2'd0, 8'h13, 3'd3, 10);
    ins_data_we = 1'b1; ins_idx = 2'd0; ins_beat = 2'd2; ins_data = 32'h0BAD_F00D;
    @(negedge clk);
    ins_data_we = 1'b0;
    run_snoop(8'h12, 2'd0, 1'b0, 2'd0, 0, 0);
    check("R11", "old tag misses", 32'(got_flags), 32'd0);
    run_snoop(8'h13, 2'd0, 1'b0, 2'd0, 1, 1);
    check("R11", "new state flags", 32'(got_flags), 32'b1010);
    check("R11", "beat0", got_beat[0], pat(10, 0));
    check("R11", "beat2 rewritten", got_beat[2], 32'h0BAD_F00D);
    check("R11", "beat3", got_beat[3], pat(10, 3));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule